// File: doc/BRIEF.md
# Three-Channel Serial ADC Block Summer

The block takes three independent serial converter streams and sums a fixed number of consecutive samples on each one. Every stream carries 32-bit frames. The frame start is marked by a sync strobe, and the signed 24-bit sample sits in the upper part of the frame, most significant bit first. All three serial lines, their clocks and their sync strobes are brought into the system clock with two-flop synchronisers. Bits are taken on the sampled rising edge of each serial clock.

Each channel adds its samples into its own 32-bit accumulator. The accumulator has 8 guard bits above the sample width. When a channel has summed `BLOCK_LEN` samples, the sum moves into a holding slot and the accumulator restarts from zero. Once all three slots are full, an SPI master sends the three sums to a downstream slave, all under one chip-select window. Capture of the next block goes on while the transfer runs. A holding slot is freed only when the transfer has finished. If a channel completes a block while its slot is still occupied, a sticky error flag is raised.

Top module: `adc_block_summer`

## Requirements
- R1: While reset is high and right after it, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 0, block_done is 0 and overrun is 0.
- R2: A frame starts on a rising serial-clock edge at which the sync strobe is high; that bit is frame bit 31, the MSB. The next 31 rising edges supply bits 30 down to 0. Rising edges with the strobe low while no frame is open are ignored.
- R3: The sample is frame bits 31..8, read as two's complement and sign-extended. Frame bits 7..0 have no effect on any sum.
- R4: Each channel sums exactly BLOCK_LEN consecutive samples into a 32-bit two's-complement total. The total is exact even when every sample is full-scale positive or full-scale negative.
- R5: After a block completes, that channel's accumulator restarts from zero, so each block's sum depends only on that block's samples.
- R6: A transfer starts only once all three channels hold a completed sum. It sends 96 bits under a single low period of spi_cs_n: channel 0, then 1, then 2, each 32 bits MSB first.
- R7: SPI mode 0 is used. spi_sclk is low whenever spi_cs_n is high, and spi_mosi does not change while spi_sclk is high.
- R8: block_done is a one-cycle pulse, raised in the same cycle that spi_cs_n returns high at the end of a transfer.
- R9: Frames that arrive during a transfer are summed into the next block without loss.
- R10: If a channel completes a block while its previous sum has not finished sending, overrun becomes 1 and stays 1 until reset. The new sum is discarded, and the previously held sum is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sclk | input | NUM_CH | Serial bit clock per channel (asynchronous) |
| adc_sdata | input | NUM_CH | Serial data per channel |
| adc_fs | input | NUM_CH | Frame sync per channel, high with the first frame bit |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI data to the slave |
| spi_cs_n | output | 1 | SPI chip select, active low |
| block_done | output | 1 | One-cycle pulse at the end of each transfer |
| overrun | output | 1 | Sticky flag: a block sum was lost |

## Verification
The bench sends stray serial clock edges before a frame opens. A capture that did not ignore them would shift garbage into the next word. It also puts non-zero values in the low frame byte, which would corrupt the sums if the slice were wrong. Full-scale positive and negative blocks catch missing sign extension and too few guard bits. A second block is started while the first is still being sent. This exposes an accumulator that is not cleared, or one that drops frames during a transfer. One channel is run two blocks ahead of the others. The flag must then latch, no transfer may start early, and the first held sum, not the later one, must come out on the SPI line.

// File: rtl/abs_pkg.sv
package abs_pkg;

    localparam int ABS_FRAME_W  = 32;
    localparam int ABS_SAMPLE_W = 24;
    localparam int ABS_GUARD_W  = 8;
    localparam int ABS_ACC_W    = ABS_SAMPLE_W + ABS_GUARD_W;

    typedef struct packed {
        logic                    valid;
        logic [ABS_SAMPLE_W-1:0] value;
    } sample_evt_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_LOW,
        TX_HIGH,
        TX_TAIL
    } tx_state_t;

    function automatic logic [ABS_ACC_W-1:0] sext_sample(input logic [ABS_SAMPLE_W-1:0] v);
        return {{(ABS_ACC_W-ABS_SAMPLE_W){v[ABS_SAMPLE_W-1]}}, v};
    endfunction

endpackage

// File: rtl/abs_serial_rx.sv
module abs_serial_rx
    import abs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_fs,
    output sample_evt_t evt
);
    localparam int CNT_W = $clog2(ABS_FRAME_W);

    logic [2:0]             clk_sync;
    logic [1:0]             dat_sync;
    logic [1:0]             fs_sync;
    logic [ABS_FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]       bit_cnt;
    logic                   rise;
    logic [ABS_FRAME_W-1:0] next_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sync <= '0;
            dat_sync <= '0;
            fs_sync  <= '0;
        end else begin
            clk_sync <= {clk_sync[1:0], ser_clk};
            dat_sync <= {dat_sync[0], ser_data};
            fs_sync  <= {fs_sync[0], ser_fs};
        end
    end

    assign rise      = clk_sync[1] & ~clk_sync[2];
    assign next_word = {shreg[ABS_FRAME_W-2:0], dat_sync[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            evt     <= '0;
        end else begin
            evt.valid <= 1'b0;
            if (rise) begin
                if (fs_sync[1]) begin
                    shreg   <= next_word;
                    bit_cnt <= CNT_W'(1);
                end else if (bit_cnt != '0) begin
                    shreg <= next_word;
                    if (bit_cnt == CNT_W'(ABS_FRAME_W-1)) begin
                        bit_cnt   <= '0;
                        evt.valid <= 1'b1;
                        evt.value <= next_word[ABS_FRAME_W-1 -: ABS_SAMPLE_W];
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
            end
        end
    end

    AST_EVT_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        evt.valid |-> $past(rise)); // R2

endmodule

// File: rtl/abs_accum.sv
module abs_accum
    import abs_pkg::*;
#(
    parameter int BLOCK_LEN = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sample_evt_t          evt,
    input  logic                 slot_release,
    output logic                 slot_valid,
    output logic [ABS_ACC_W-1:0] slot_sum,
    output logic                 ovr_pulse
);
    localparam int CNT_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;

    logic [ABS_ACC_W-1:0] acc;
    logic [CNT_W-1:0]     cnt;
    logic [ABS_ACC_W-1:0] addend;
    logic [ABS_ACC_W-1:0] total;

    assign addend = sext_sample(evt.value);
    assign total  = acc + addend;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            cnt        <= '0;
            slot_valid <= 1'b0;
            slot_sum   <= '0;
            ovr_pulse  <= 1'b0;
        end else begin
            ovr_pulse <= 1'b0;
            if (slot_release) begin
                slot_valid <= 1'b0;
            end
            if (evt.valid) begin
                if (cnt == CNT_W'(BLOCK_LEN-1)) begin
                    cnt <= '0;
                    acc <= '0;
                    if (slot_valid) begin
                        ovr_pulse <= 1'b1;
                    end else begin
                        slot_sum   <= total;
                        slot_valid <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + CNT_W'(1);
                    acc <= total;
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && acc[ABS_ACC_W-1] == addend[ABS_ACC_W-1])
            |-> total[ABS_ACC_W-1] == acc[ABS_ACC_W-1]); // R4
    AST_SLOT_HELD: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && !slot_release) |=> (slot_valid && $stable(slot_sum))); // R10

endmodule

// File: rtl/abs_spi_tx.sv
module abs_spi_tx
    import abs_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int SCLK_DIV = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [NUM_CH*ABS_ACC_W-1:0] words,
    output logic                        busy,
    output logic                        sclk,
    output logic                        mosi,
    output logic                        cs_n,
    output logic                        done
);
    localparam int TOT_BITS = NUM_CH * ABS_ACC_W;
    localparam int IDX_W    = $clog2(TOT_BITS);
    localparam int DIV_W    = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;

    tx_state_t           state;
    logic [TOT_BITS-1:0] shreg;
    logic [IDX_W-1:0]    bit_idx;
    logic [DIV_W-1:0]    div_cnt;
    logic                div_end;

    assign busy    = (state != TX_IDLE);
    assign div_end = (div_cnt == DIV_W'(SCLK_DIV-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            div_cnt <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        shreg   <= words;
                        mosi    <= words[TOT_BITS-1];
                        cs_n    <= 1'b0;
                        bit_idx <= '0;
                        div_cnt <= '0;
                        state   <= TX_LOW;
                    end
                end
                TX_LOW: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        sclk    <= 1'b1;
                        state   <= TX_HIGH;
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
                TX_HIGH: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        sclk    <= 1'b0;
                        if (bit_idx == IDX_W'(TOT_BITS-1)) begin
                            state <= TX_TAIL;
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                            shreg   <= {shreg[TOT_BITS-2:0], 1'b0};
                            mosi    <= shreg[TOT_BITS-2];
                            state   <= TX_LOW;
                        end
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
                default: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        cs_n    <= 1'b1;
                        mosi    <= 1'b0;
                        done    <= 1'b1;
                        state   <= TX_IDLE;
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
            endcase
        end
    end

    AST_CS_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk); // R7
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done); // R8

endmodule

// File: rtl/adc_block_summer.sv
module adc_block_summer
    import abs_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int BLOCK_LEN = 256,
    parameter int SCLK_DIV  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] adc_sclk,
    input  logic [NUM_CH-1:0] adc_sdata,
    input  logic [NUM_CH-1:0] adc_fs,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              block_done,
    output logic              overrun
);
    localparam int WORDS_W = NUM_CH * ABS_ACC_W;

    sample_evt_t          evt       [NUM_CH];
    logic [ABS_ACC_W-1:0] slot_sum  [NUM_CH];
    logic [NUM_CH-1:0]    slot_valid;
    logic [NUM_CH-1:0]    ovr_pulse;
    logic [WORDS_W-1:0]   words;
    logic                 spi_busy;
    logic                 spi_start;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        abs_serial_rx u_rx (
            .clk      (clk),
            .rst      (rst),
            .ser_clk  (adc_sclk[ch]),
            .ser_data (adc_sdata[ch]),
            .ser_fs   (adc_fs[ch]),
            .evt      (evt[ch])
        );

        abs_accum #(.BLOCK_LEN(BLOCK_LEN)) u_acc (
            .clk          (clk),
            .rst          (rst),
            .evt          (evt[ch]),
            .slot_release (block_done),
            .slot_valid   (slot_valid[ch]),
            .slot_sum     (slot_sum[ch]),
            .ovr_pulse    (ovr_pulse[ch])
        );

        assign words[(NUM_CH-1-ch)*ABS_ACC_W +: ABS_ACC_W] = slot_sum[ch];
    end

    assign spi_start = (&slot_valid) & ~spi_busy & ~block_done;

    abs_spi_tx #(.NUM_CH(NUM_CH), .SCLK_DIV(SCLK_DIV)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .start (spi_start),
        .words (words),
        .busy  (spi_busy),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n),
        .done  (block_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
        end else if (|ovr_pulse) begin
            overrun <= 1'b1;
        end
    end

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R10
    AST_START_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> $past(&slot_valid)); // R6

endmodule

// File: tb/adc_block_summer_bench.sv
module adc_block_summer_bench;

    localparam int NCH = 3;
    localparam int BL  = 4;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] adc_sclk  = '0;
    logic [NCH-1:0] adc_sdata = '0;
    logic [NCH-1:0] adc_fs    = '0;
    logic spi_sclk, spi_mosi, spi_cs_n, block_done, overrun;

    always #2 clk = ~clk;

    adc_block_summer #(.NUM_CH(NCH), .BLOCK_LEN(BL), .SCLK_DIV(2)) u_adc_block_summer (
        .clk        (clk),
        .rst        (rst),
        .adc_sclk   (adc_sclk),
        .adc_sdata  (adc_sdata),
        .adc_fs     (adc_fs),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .spi_cs_n   (spi_cs_n),
        .block_done (block_done),
        .overrun    (overrun)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference model
    int acc [NCH];
    int cnt [NCH];
    int slot [NCH];
    bit sv [NCH];
    bit in_flight = 0;
    bit exp_ovr = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    string cur_tag = "R4";
    int n_done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // SPI monitor, compared every clock
    bit prev_sclk = 0, prev_cs = 1, prev_mosi = 0;
    logic [95:0] rx_bits = '0;
    int nbits = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check(!(spi_cs_n && spi_sclk), "R7", "sclk low while deselected", spi_sclk, 0);
            if (spi_sclk && prev_sclk)
                check(spi_mosi == prev_mosi, "R7", "mosi stable while sclk high", spi_mosi, prev_mosi);
            if (!spi_cs_n && prev_cs) nbits = 0;
            if (spi_sclk && !prev_sclk && !spi_cs_n) begin
                rx_bits = {rx_bits[94:0], spi_mosi};
                nbits++;
            end
            if (spi_cs_n && !prev_cs) begin
                check(nbits == 96, "R6", "bits per transfer", nbits, 96);
                check(block_done == 1'b1, "R8", "done with cs rise", block_done, 1);
                for (int ch = 0; ch < NCH; ch++) begin
                    logic [31:0] got;
                    got = rx_bits[95-32*ch -: 32];
                    if (exp_q.size() > 0) begin
                        logic [31:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(got == e, t, $sformatf("channel %0d sum", ch), got, e);
                    end else begin
                        check(0, "R6", "unexpected transfer", got, 0);
                    end
                end
                for (int ch = 0; ch < NCH; ch++) sv[ch] = 0;
                in_flight = 0;
                n_done++;
            end else if (block_done) begin
                check(0, "R8", "done without cs rise", block_done, 0);
            end
            prev_sclk = spi_sclk;
            prev_cs   = spi_cs_n;
            prev_mosi = spi_mosi;
        end
    end

    task automatic model_sample(input int ch, input int s);
        acc[ch] += s;
        cnt[ch]++;
        if (cnt[ch] == BL) begin
            cnt[ch] = 0;
            if (sv[ch]) exp_ovr = 1;
            else begin
                slot[ch] = acc[ch];
                sv[ch] = 1;
            end
            acc[ch] = 0;
        end
        if (sv[0] && sv[1] && sv[2] && !in_flight) begin
            for (int k = 0; k < NCH; k++) begin
                exp_q.push_back(slot[k]);
                tag_q.push_back(cur_tag);
            end
            in_flight = 1;
        end
    endtask

    task automatic send_frame(input logic [2:0] mask, input int s0, input int s1,
                              input int s2, input logic [7:0] low);
        logic [31:0] w [NCH];
        int s [NCH];
        s[0] = s0; s[1] = s1; s[2] = s2;
        for (int ch = 0; ch < NCH; ch++) w[ch] = {s[ch][23:0], low};
        for (int b = 31; b >= 0; b--) begin
            for (int ch = 0; ch < NCH; ch++) begin
                adc_sdata[ch] = w[ch][b];
                adc_fs[ch]    = mask[ch] && (b == 31);
            end
            wait_cyc(HALF);
            adc_sclk = mask;
            wait_cyc(HALF);
            adc_sclk = '0;
        end
        adc_fs = '0;
        for (int ch = 0; ch < NCH; ch++)
            if (mask[ch]) model_sample(ch, s[ch]);
    endtask

    task automatic stray_clocks(input int n);
        adc_sdata = '1;
        adc_fs = '0;
        for (int i = 0; i < n; i++) begin
            wait_cyc(HALF);
            adc_sclk = '1;
            wait_cyc(HALF);
            adc_sclk = '0;
        end
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (n_done < target && t < 5000) begin
            wait_cyc(1);
            t++;
        end
        check(n_done >= target, "R6", "transfer completed", n_done, target);
    endtask

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin
            acc[ch] = 0; cnt[ch] = 0; slot[ch] = 0; sv[ch] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
        wait_cyc(6);
        rst = 1'b0;
        wait_cyc(2);
        check(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
        check(spi_mosi == 1'b0, "R1", "mosi after reset", spi_mosi, 0);
        check(block_done == 1'b0, "R1", "done after reset", block_done, 0);
        check(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);

        // block A: stray edges, low byte noise, full-scale positive
        cur_tag = "R2 R3 R4";
        stray_clocks(5);
        send_frame(3'b111, 1, -1, 32'h7FFFFF, 8'hA5);
        stray_clocks(3);
        send_frame(3'b111, 2, -100, 32'h7FFFFF, 8'hFF);
        send_frame(3'b111, 3, -5000, 32'h7FFFFF, 8'h5A);
        send_frame(3'b111, 4, -8388608, 32'h7FFFFF, 8'h01);
        wait_done(1);

        // block B then C back to back; C frames arrive during B's transfer
        cur_tag = "R4 R5";
        send_frame(3'b111, -8388608, 10, -3, 8'h00);
        send_frame(3'b111, -8388608, 20, -3, 8'h33);
        send_frame(3'b111, -8388608, 30, -3, 8'hC0);
        send_frame(3'b111, -8388608, 40, -3, 8'h0F);
        cur_tag = "R9 R5";
        send_frame(3'b111, 100, 7, 123456, 8'h11);
        send_frame(3'b111, 200, 7, -123456, 8'h22);
        send_frame(3'b111, 300, 7, 999, 8'h44);
        send_frame(3'b111, -600, 7, 1, 8'h88);
        wait_done(3);
        check(overrun == 1'b0, "R10", "no overrun in normal flow", overrun, 0);

        // channel 0 runs two blocks ahead
        cur_tag = "R10";
        for (int i = 0; i < BL; i++) send_frame(3'b001, 7, 0, 0, 8'h00);
        for (int i = 0; i < BL; i++) send_frame(3'b001, 9, 0, 0, 8'h00);
        wait_cyc(20);
        check(overrun == exp_ovr, "R10", "overrun raised", overrun, exp_ovr);
        check(spi_cs_n == 1'b1, "R6", "no transfer with slots missing", spi_cs_n, 1);
        for (int i = 0; i < BL; i++) send_frame(3'b110, 0, i, -i, 8'h77);
        wait_done(4);
        wait_cyc(20);
        check(overrun == 1'b1, "R10", "overrun sticky", overrun, 1);
        check(n_done == 4, "R8", "done pulse count", n_done, 4);
        check(exp_q.size() == 0, "R6", "all expected sums sent", exp_q.size(), 0);

        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule